// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the control and configuration words of a system bridge in a small, word-addressed register file. A host reaches it through a plain register bus carrying a byte address, a write strobe, a read strobe and 32-bit data. Most words are ordinary storage, and their values are driven out on a flat export bus to the logic they configure. A few words behave differently. An interrupt-enable word can only be changed through a separate set word and a separate clear word. A status word and the enable word cannot be written. A self-reset bit in the general configuration word asks for a system reset when software moves it from 0 to 1.

Only aligned 32-bit accesses are honoured. Read data is registered, and the reset request comes out as a registered single-cycle pulse. After reset, several words carry fixed defaults, so a system comes up in a known configuration. The self-reset bit starts set, so the first write that keeps it set does not trigger a reset.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: Twenty-eight 32-bit words sit at byte offsets 0x00, 0x04, ... 0x6C, one word per offset divided by 4. A write to an ordinary word stores the full 32-bit value, and the value appears on `cfg_flat[32*i +: 32]` in the next cycle.
- R2: An access whose address bits [1:0] are not 00 is ignored. Such a write changes no word, and such a read returns 0.
- R3: A write to offset 0x30 stores the value in that word and also ORs it into the enable word at offset 0x38.
- R4: A write to offset 0x34 stores the value in that word and also clears, in the enable word at 0x38, every bit that is 1 in the written value.
- R5: Writes to offset 0x38 (enable), to offset 0x3C (status) and to offsets 0x70 to 0x7C change nothing. The status word always reads 0. A read of offsets 0x70 to 0x7C returns 0.
- R6: A write to offset 0x04 whose bit 2 is 1 while the stored bit 2 is 0 stores the value. It also drives `sys_reset_req` high during the cycle that follows the write's clock edge.
- R7: A write to offset 0x04 raises no reset request when the stored bit 2 is already 1, or when the written bit 2 is 0.
- R8: Reset values: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. All other words reset to 0.
- R9: `bus_rdata` captures the addressed word at the clock edge where `bus_rd` is sampled and holds it until the next read. A read in the same cycle as a write returns the value from before the write. Reads of 0x30 and 0x34 return the stored value.
- R10: `sys_reset_req` is low during reset and is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 7 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| cfg_flat | output | 896 | All 28 words, word i at bits [32*i+31:32*i] |

## Verification
The bench targets the self-reset edge in three forms. It rewrites the bit while it is already 1 (a level-sensitive design would reset here), clears the bit, and then sets it again (a design that compares against the new value would never reset). It runs set and clear writes back to back on overlapping bit patterns. A design that overwrites the enable word instead of merging into it, or that leaves set and clear unstored, shows up at once. It also makes misaligned, unmapped and read-only writes, and it reads and writes the same word in one cycle, where a combinational read path would return the new value.

// File: rtl/bcr_pkg.sv
// Shared sizes, word indices and reset defaults of the bridge control
// register file. Assumes 32-bit words and byte addressing.
package bcr_pkg;
    localparam int DW     = 32;
    localparam int NREG   = 28;
    localparam int AW     = 7;
    localparam int IDXW   = AW - 2;

    localparam int IDX_GCFG = 1;   // general configuration word (0x04)
    localparam int IDX_SET  = 12;  // enable-set word (0x30)
    localparam int IDX_CLR  = 13;  // enable-clear word (0x34)
    localparam int IDX_EN   = 14;  // enable word, read-only (0x38)
    localparam int IDX_ISR  = 15;  // status word, read-only (0x3C)
    localparam int SELF_RST_BIT = 2;

    // Reset default of each word.
    function automatic logic [DW-1:0] reset_value(input int idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/bcr_decode.sv
// Address decoder: turns a byte address and strobes into per-word write
// selects and special-write flags. Assumes one access per cycle.
module bcr_decode
    import bcr_pkg::*;
(
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    output logic            hit,
    output logic [IDXW-1:0] idx,
    output logic [NREG-1:0] wr_sel,
    output logic            wr_set,
    output logic            wr_clr,
    output logic            wr_gcfg
);
    // Word index and validity: aligned and inside the populated range.
    always_comb begin
        idx = addr[AW-1:2];
        hit = (addr[1:0] == 2'b00) && (idx < IDXW'(NREG));
    end

    // Plain-store select for each word; the read-only words never get one.
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        if (g == IDX_EN || g == IDX_ISR) begin : g_ro
            assign wr_sel[g] = 1'b0;
        end else begin : g_rw
            assign wr_sel[g] = wr && hit && (idx == IDXW'(g));
        end
    end

    // Flags for the writes that have side effects.
    always_comb begin
        wr_set  = wr && hit && (idx == IDXW'(IDX_SET));
        wr_clr  = wr && hit && (idx == IDXW'(IDX_CLR));
        wr_gcfg = wr && hit && (idx == IDXW'(IDX_GCFG));
    end
endmodule

// File: rtl/bcr_store.sv
// Storage of all words. Ordinary words load on their select; the enable
// word merges set/clear data; the status word is held at zero.
// Assumes at most one select or flag is active per cycle.
module bcr_store
    import bcr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG-1:0]    wr_sel,
    input  logic               wr_set,
    input  logic               wr_clr,
    input  logic [DW-1:0]      wdata,
    output logic [NREG*DW-1:0] flat
);
    logic unused_ro_sel;
    assign unused_ro_sel = wr_sel[IDX_EN] ^ wr_sel[IDX_ISR];

    for (genvar g = 0; g < NREG; g++) begin : g_word
        logic [DW-1:0] q;
        if (g == IDX_EN) begin : g_en
            // Enable word: OR on set writes, AND-NOT on clear writes.
            always_ff @(posedge clk) begin
                if (!rst_n)      q <= reset_value(g);
                else if (wr_set) q <= q | wdata;
                else if (wr_clr) q <= q & ~wdata;
            end
        end else if (g == IDX_ISR) begin : g_isr
            assign q = '0;
        end else begin : g_plain
            // Ordinary word: load full value on its select.
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= reset_value(g);
                else if (wr_sel[g]) q <= wdata;
            end
        end
        assign flat[g*DW +: DW] = q;
    end
endmodule

// File: rtl/bcr_rstreq.sv
// Self-reset request: a one-cycle registered pulse when a configuration
// write moves the trigger bit from 0 to 1. Assumes old_bit is the stored
// value before the write.
module bcr_rstreq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_gcfg,
    input  logic old_bit,
    input  logic new_bit,
    output logic req
);
    // Register the rising-edge condition of the trigger bit.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= wr_gcfg && !old_bit && new_bit;
    end
endmodule

// File: rtl/bridge_ctrl_regs.sv
// Bridge control register file top: decode, storage, registered read
// port and self-reset pulse. Assumes aligned 32-bit accesses only.
module bridge_ctrl_regs
    import bcr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               sys_reset_req,
    output logic [NREG*DW-1:0] cfg_flat
);
    logic            hit;
    logic [IDXW-1:0] idx;
    logic [NREG-1:0] wr_sel;
    logic            wr_set, wr_clr, wr_gcfg;
    logic [DW-1:0]   words [NREG];

    bcr_decode u_dec (
        .addr(bus_addr), .wr(bus_wr), .hit(hit), .idx(idx),
        .wr_sel(wr_sel), .wr_set(wr_set), .wr_clr(wr_clr), .wr_gcfg(wr_gcfg)
    );

    bcr_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_set(wr_set),
        .wr_clr(wr_clr), .wdata(bus_wdata), .flat(cfg_flat)
    );

    bcr_rstreq u_rst (
        .clk(clk), .rst_n(rst_n), .wr_gcfg(wr_gcfg),
        .old_bit(cfg_flat[IDX_GCFG*DW + SELF_RST_BIT]),
        .new_bit(bus_wdata[SELF_RST_BIT]), .req(sys_reset_req)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_view
        assign words[g] = cfg_flat[g*DW +: DW];
    end

    // Registered read port: capture on read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= hit ? words[idx] : '0;
    end
endmodule

// File: rtl/bcr_checker.sv
// Property checker for the bridge control register file, bound to the top.
module bcr_checker
    import bcr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [AW-1:0]      bus_addr,
    input logic               bus_wr,
    input logic [DW-1:0]      bus_wdata,
    input logic               sys_reset_req,
    input logic [NREG*DW-1:0] cfg_flat
);
    logic [DW-1:0] en_w, isr_w;
    assign en_w  = cfg_flat[IDX_EN*DW +: DW];
    assign isr_w = cfg_flat[IDX_ISR*DW +: DW];

    p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    p_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(bus_wr && bus_addr == 7'h04 && bus_wdata[SELF_RST_BIT]));

    p_en_only_via_set_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_w) |-> $past(bus_wr && (bus_addr == 7'h30 || bus_addr == 7'h34)));

    p_isr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        isr_w == '0);

    p_set_merges_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_wr && bus_addr == 7'h30) |-> ((en_w & $past(bus_wdata)) == $past(bus_wdata)));

    p_clr_merges_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_wr && bus_addr == 7'h34) |-> ((en_w & $past(bus_wdata)) == '0));
endmodule

bind bridge_ctrl_regs bcr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .sys_reset_req(sys_reset_req), .cfg_flat(cfg_flat)
);

// File: tb/bridge_ctrl_regs_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every clock, plus directed
// checks per requirement.
module bridge_ctrl_regs_bench;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          sys_reset_req;
    logic [895:0]  cfg_flat;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    int unsigned m [28];
    logic [31:0] exp_rd = '0;
    bit          exp_req = 0;

    always #4 clk = ~clk;

    bridge_ctrl_regs u_bridge_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_reset_req(sys_reset_req), .cfg_flat(cfg_flat)
    );

    // Reference model, updated at each rising edge from the stable inputs.
    always @(posedge clk) begin
        int k;
        bit ok;
        k  = int'(bus_addr) / 4;
        ok = (bus_addr[1:0] == 0) && (k < 28);
        if (!rst_n) begin
            for (int i = 0; i < 28; i++) m[i] = 0;
            m[0] = 32'hC40; m[1] = 32'h1384; m[2] = 32'h2BFF8010;
            m[3] = 32'h255E0091; m[4] = 32'h6140; m[7] = 32'h1FF;
            m[8] = 32'h1FF; m[26] = 32'h8; m[27] = 32'h10000000;
            exp_rd = 0; exp_req = 0;
        end else begin
            exp_req = bus_wr && ok && k == 1 && !m[1][2] && bus_wdata[2];
            if (bus_rd) exp_rd = ok ? m[k] : 0;
            if (bus_wr && ok) begin
                if (k == 12) begin m[12] = bus_wdata; m[14] = m[14] | bus_wdata; end
                else if (k == 13) begin m[13] = bus_wdata; m[14] = m[14] & ~bus_wdata; end
                else if (k != 14 && k != 15) m[k] = bus_wdata;
            end
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (!done) begin
            nchk++;
            if (bus_rdata !== exp_rd) begin
                nfail++; $display("FAIL R9 rdata got %h exp %h", bus_rdata, exp_rd);
            end
            if (sys_reset_req !== exp_req) begin
                nfail++; $display("FAIL R6 req got %b exp %b", sys_reset_req, exp_req);
            end
            for (int i = 0; i < 28; i++)
                if (cfg_flat[i*32 +: 32] !== m[i]) begin
                    nfail++; $display("FAIL R1 word %0d got %h exp %h", i, cfg_flat[i*32 +: 32], m[i]);
                end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++; $display("FAIL %s got %h exp %h", tag, act, expv);
        end
    endtask

    task automatic wr32(input logic [6:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd32(input logic [6:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1;
        @(negedge clk); bus_rd = 0; v = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R10 req in reset", {31'b0, sys_reset_req}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        // R8 reset defaults
        rd32(7'h00, v); chk("R8 0x00", v, 32'h00000C40);
        rd32(7'h04, v); chk("R8 0x04", v, 32'h00001384);
        rd32(7'h08, v); chk("R8 0x08", v, 32'h2BFF8010);
        rd32(7'h0C, v); chk("R8 0x0C", v, 32'h255E0091);
        rd32(7'h10, v); chk("R8 0x10", v, 32'h00006140);
        rd32(7'h1C, v); chk("R8 0x1C", v, 32'h000001FF);
        rd32(7'h20, v); chk("R8 0x20", v, 32'h000001FF);
        rd32(7'h68, v); chk("R8 0x68", v, 32'h00000008);
        rd32(7'h6C, v); chk("R8 0x6C", v, 32'h10000000);
        rd32(7'h14, v); chk("R8 0x14 zero", v, 32'h0);
        // R7 rewrite with bit already 1, then clear bit
        wr32(7'h04, 32'h00001384); chk("R7 already set", {31'b0, sys_reset_req}, 32'h0);
        wr32(7'h04, 32'h00000000); chk("R7 clear bit", {31'b0, sys_reset_req}, 32'h0);
        // R6 edge 0 -> 1, R10 width one cycle
        wr32(7'h04, 32'h00000004); chk("R6 pulse", {31'b0, sys_reset_req}, 32'h1);
        @(negedge clk); chk("R10 pulse ends", {31'b0, sys_reset_req}, 32'h0);
        rd32(7'h04, v); chk("R6 stored", v, 32'h4);
        // R3 / R4 set and clear
        wr32(7'h30, 32'h000000F0); rd32(7'h38, v); chk("R3 set", v, 32'hF0);
        wr32(7'h30, 32'h0000000F); rd32(7'h38, v); chk("R3 or-merge", v, 32'hFF);
        rd32(7'h30, v); chk("R3 set stored", v, 32'h0F);
        wr32(7'h34, 32'h0000003C); rd32(7'h38, v); chk("R4 clear", v, 32'hC3);
        rd32(7'h34, v); chk("R4 clr stored", v, 32'h3C);
        // R5 read-only and unmapped
        wr32(7'h38, 32'hFFFFFFFF); rd32(7'h38, v); chk("R5 en ro", v, 32'hC3);
        wr32(7'h3C, 32'h12345678); rd32(7'h3C, v); chk("R5 isr ro", v, 32'h0);
        wr32(7'h70, 32'hDEADBEEF); rd32(7'h70, v); chk("R5 unmapped", v, 32'h0);
        rd32(7'h7C, v); chk("R5 unmapped top", v, 32'h0);
        // R2 misaligned
        wr32(7'h41, 32'hAAAA5555); rd32(7'h40, v); chk("R2 misaligned wr", v, 32'h0);
        wr32(7'h40, 32'h11112222); rd32(7'h42, v); chk("R2 misaligned rd", v, 32'h0);
        // R1 plain words
        for (int i = 0; i < 28; i++) begin
            if (i != 1 && i != 12 && i != 13 && i != 14 && i != 15)
                wr32(7'(i*4), 32'hA5000000 ^ (i * 32'h01010101));
        end
        for (int i = 0; i < 28; i++) begin
            if (i != 1 && i != 12 && i != 13 && i != 14 && i != 15) begin
                rd32(7'(i*4), v); chk("R1 store", v, 32'hA5000000 ^ (i * 32'h01010101));
            end
        end
        // R9 read with concurrent write returns old; hold without read
        bus_addr = 7'h18; bus_wdata = 32'h0BADF00D; bus_wr = 1; bus_rd = 1;
        @(negedge clk); bus_wr = 0; bus_rd = 0;
        chk("R9 old value", bus_rdata, 32'hA5000000 ^ (6 * 32'h01010101));
        @(negedge clk); chk("R9 hold", bus_rdata, 32'hA5000000 ^ (6 * 32'h01010101));
        rd32(7'h18, v); chk("R9 new value", v, 32'h0BADF00D);
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1; nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule